// File: doc/BRIEF.md
# External Interrupt Request Flag Controller

This block watches eight external interrupt pins and keeps one request flag per pin. Each pin has its own sensing choice. A per-pin level-select bit picks active-low level sensing. Otherwise a 2-bit edge field picks falling, rising or both edges. Every pin passes through a synchronizer before any event is judged. The synchronizer registers reset to high, so an idle pin counts as inactive.

The flags are visible to software as the low byte of a 16-bit status word. The upper byte is always zero. A flag is dropped in one of three ways:
- software writes 0 to it, but only after a status read has returned that flag as 1;
- the exception logic sends an acknowledge for the pin;
- the transfer controller acknowledges a start for the pin while its disable-select input is low.

A new event always beats a clear that lands in the same cycle. One request line per pin goes to the priority logic.

The register bus has no back-pressure. A read strobe or write strobe is taken in the cycle it is high. Read data is the current status word, combinationally, with no wait state. Configuration and acknowledge pins are plain level or pulse inputs.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every flag is 0, the status word reads 0x0000 and every request output is 0 while its pin input is high.
- R2: Status word bit n (n = 0..7) carries the flag of pin n. Bits 15..8 always read 0, and writing ones to them changes nothing.
- R3: With level-select 0, the edge field of pin n is sense_mode_i[2n+1:2n]. Code 00 sets the flag on a falling edge, 01 on a rising edge and 10 on either edge. The flag becomes visible at the third rising clock edge counted from the pin change, and not at the second.
- R4: With level-select 1, the flag sets in every cycle in which the synchronized pin is low. The request output equals the inverse of the synchronized pin, so it drops once the pin returns high even while the flag is still held.
- R5: A write clears status bit n when it carries a 0 in bit n and a read has returned bit n as 1 since the previous write. A write of 1 has no effect. Any write disarms all bits, so a second write of 0 without a fresh read leaves the flag set.
- R6: In an edge mode, an exception acknowledge for pin n clears flag n.
- R7: In level mode, an exception acknowledge for pin n clears flag n only if the synchronized pin is high. While the pin is low the flag remains 1.
- R8: A transfer-controller acknowledge for pin n clears flag n when dtc_disel_i is 0, and has no effect when dtc_disel_i is 1.
- R9: If a detected event and any clear for the same pin fall in the same cycle, the flag ends that cycle at 1.
- R10: With level-select 0 and edge code 11, the pin never sets its flag, and cfg_err_o[n] is 1 for as long as that code is applied.
- R11: In the edge modes, irq_req_o[n] equals flag n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 8 | External interrupt pins, asynchronous |
| sense_mode_i | input | 16 | Edge code per pin, bits 2n+1:2n for pin n |
| level_sel_i | input | 8 | Per pin: 1 selects low-level sensing |
| reg_rd_i | input | 1 | Status read strobe |
| reg_wr_i | input | 1 | Status write strobe |
| reg_wdata_i | input | 16 | Status write data |
| reg_rdata_o | output | 16 | Status word |
| exc_ack_i | input | 8 | Exception-processing acknowledge per pin |
| dtc_ack_i | input | 8 | Transfer-controller start acknowledge per pin |
| dtc_disel_i | input | 1 | Transfer-controller disable-select bit |
| irq_req_o | output | 8 | Request line per pin |
| cfg_err_o | output | 8 | Illegal edge code per pin |

## Verification
Two functions can meet in one cycle: an event that sets a flag, and an acknowledge that clears the same flag. The bench sets a flag in both-edge mode and then toggles the pin. Counting the synchronizer and history registers, it raises the exception acknowledge so that the acknowledge is sampled at the very edge where the new event is registered. The status word must still show the flag afterwards. A bare acknowledge given afterwards must then clear it, which shows that the first clear was overridden and not ignored.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  typedef enum logic [1:0] {
    SENSE_FALL = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_BOTH = 2'b10,
    SENSE_BAD  = 2'b11
  } sense_e;

  localparam int STATUS_W = 16;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] sync_o,
  output logic [NUM_PINS-1:0] prev_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];
  logic [NUM_PINS-1:0] prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  // History of the synchronized sample, used for edge comparison
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= stage_q[LAST];
  end

  assign sync_o = stage_q[LAST];
  assign prev_o = prev_q;

endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect
  import irq_flag_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0]   level_sel_i,
  input  logic [NUM_PINS-1:0]   sync_i,
  input  logic [NUM_PINS-1:0]   prev_i,
  output logic [NUM_PINS-1:0]   evt_o,
  output logic [NUM_PINS-1:0]   is_level_o,
  output logic [NUM_PINS-1:0]   cfg_err_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    sense_e mode;
    logic   fall, rise;

    assign mode = sense_e'(sense_i[2*g +: 2]);
    assign fall = prev_i[g] & ~sync_i[g];
    assign rise = ~prev_i[g] & sync_i[g];

    always_comb begin
      evt_o[g]     = 1'b0;
      cfg_err_o[g] = 1'b0;
      if (level_sel_i[g]) begin
        evt_o[g] = ~sync_i[g];
      end else begin
        unique case (mode)
          SENSE_FALL: evt_o[g] = fall;
          SENSE_RISE: evt_o[g] = rise;
          SENSE_BOTH: evt_o[g] = fall | rise;
          SENSE_BAD:  cfg_err_o[g] = 1'b1;
          default:    evt_o[g] = 1'b0;
        endcase
      end
    end

    assign is_level_o[g] = level_sel_i[g];

    // R10: an illegal code never produces an event
    a_r10_bad_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o[g] |-> !evt_o[g]);
  end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic [NUM_PINS-1:0] is_level_i,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] exc_ack_i,
  input  logic [NUM_PINS-1:0] dtc_ack_i,
  input  logic                dtc_disel_i,
  output logic [NUM_PINS-1:0] flag_o
);

  logic [NUM_PINS-1:0] flag_q, flag_d;
  logic [NUM_PINS-1:0] armed_q, armed_d;
  logic [NUM_PINS-1:0] clr_sw, clr_exc, clr_dtc;

  assign clr_sw  = {NUM_PINS{wr_i}} & armed_q & ~wdata_i;
  assign clr_exc = exc_ack_i & (~is_level_i | sync_i);
  assign clr_dtc = dtc_ack_i & {NUM_PINS{~dtc_disel_i}};

  // New events override any clear in the same cycle
  assign flag_d = evt_i | (flag_q & ~(clr_sw | clr_exc | clr_dtc));

  // A bit arms when read as 1, disarms on any write or once its flag is gone
  always_comb begin
    if (wr_i) armed_d = '0;
    else      armed_d = (armed_q & flag_q) | ({NUM_PINS{rd_i}} & flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      armed_q <= '0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    // R9: an event always leaves the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> flag_q[g]);
    // R5: without arming and without acknowledges, a set flag holds
    a_r5_unarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !armed_q[g] && !exc_ack_i[g] && !dtc_ack_i[g]) |=> flag_q[g]);
    // R5: arming needs a read that saw the flag
    a_r5_arm_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q[g]) |-> $past(rd_i && flag_q[g]));
    // R6: exception acknowledge in an edge mode clears
    a_r6_exc_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_ack_i[g] && !is_level_i[g] && !evt_i[g]) |=> !flag_q[g]);
    // R8: transfer acknowledge with disable-select low clears
    a_r8_dtc_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (dtc_ack_i[g] && !dtc_disel_i && !evt_i[g]) |=> !flag_q[g]);
  end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   irq_pin_i,
  input  logic [2*NUM_PINS-1:0] sense_mode_i,
  input  logic [NUM_PINS-1:0]   level_sel_i,
  input  logic                  reg_rd_i,
  input  logic                  reg_wr_i,
  input  logic [STATUS_W-1:0]   reg_wdata_i,
  output logic [STATUS_W-1:0]   reg_rdata_o,
  input  logic [NUM_PINS-1:0]   exc_ack_i,
  input  logic [NUM_PINS-1:0]   dtc_ack_i,
  input  logic                  dtc_disel_i,
  output logic [NUM_PINS-1:0]   irq_req_o,
  output logic [NUM_PINS-1:0]   cfg_err_o
);

  localparam int PAD_W = STATUS_W - NUM_PINS;

  logic [NUM_PINS-1:0] sync_w, prev_w, evt_w, level_w, flag_w;

  irq_pin_sync #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (irq_pin_i),
    .sync_o(sync_w),
    .prev_o(prev_w)
  );

  irq_event_detect #(
    .NUM_PINS(NUM_PINS)
  ) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .sense_i    (sense_mode_i),
    .level_sel_i(level_sel_i),
    .sync_i     (sync_w),
    .prev_i     (prev_w),
    .evt_o      (evt_w),
    .is_level_o (level_w),
    .cfg_err_o  (cfg_err_o)
  );

  irq_flag_bank #(
    .NUM_PINS(NUM_PINS)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_w),
    .is_level_i (level_w),
    .sync_i     (sync_w),
    .rd_i       (reg_rd_i),
    .wr_i       (reg_wr_i),
    .wdata_i    (reg_wdata_i[NUM_PINS-1:0]),
    .exc_ack_i  (exc_ack_i),
    .dtc_ack_i  (dtc_ack_i),
    .dtc_disel_i(dtc_disel_i),
    .flag_o     (flag_w)
  );

  assign reg_rdata_o = {{PAD_W{1'b0}}, flag_w};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_req
    assign irq_req_o[g] = level_w[g] ? ~sync_w[g] : flag_w[g];

    // R11: in an edge mode, a request line that rose follows a flag that was set
    a_r11_edge_req_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_sel_i[g] && $rose(irq_req_o[g])) |-> reg_rdata_o[g]);
  end

endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;

  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin = '1;
  logic [2*N-1:0] sense = '0;
  logic [N-1:0]  lvl = '0;
  logic          rd = 1'b0;
  logic          wr = 1'b0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [N-1:0]  exc = '0;
  logic [N-1:0]  dtc = '0;
  logic          disel = 1'b1;
  logic [N-1:0]  req;
  logic [N-1:0]  cerr;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pin_i   (pin),
    .sense_mode_i(sense),
    .level_sel_i (lvl),
    .reg_rd_i    (rd),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .exc_ack_i   (exc),
    .dtc_ack_i   (dtc),
    .dtc_disel_i (disel),
    .irq_req_o   (req),
    .cfg_err_o   (cerr)
  );

  // vector: {edge code[1:0], start level, final level, expected flag}
  localparam logic [4:0] TBL [9] = '{
    {2'b00, 1'b1, 1'b0, 1'b1},
    {2'b00, 1'b0, 1'b1, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b1},
    {2'b10, 1'b0, 1'b1, 1'b1},
    {2'b11, 1'b1, 1'b0, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b0},
    {2'b00, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(output logic [15:0] v);
    rd = 1'b1;
    #1 v = rdata;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] v);
    wr = 1'b1;
    wdata = v;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
    wdata = '0;
  endtask

  task automatic clear_all();
    logic [15:0] t;
    do_read(t);
    do_write(16'h0000);
  endtask

  task automatic pulse_exc(input int p);
    exc[p] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exc = '0;
  endtask

  task automatic pulse_dtc(input int p);
    dtc[p] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dtc = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    chk("R1 status after reset", rdata, 16'h0000);
    chk("R1 req after reset", req, '0);
    chk("R10 no cfg error for code 00", cerr, '0);

    // table of edge-mode vectors
    for (int i = 0; i < 9; i++) begin
      int p;
      p = i % N;
      sense[2*p +: 2] = TBL[i][4:3];
      pin[p] = TBL[i][2];
      cyc(4);
      clear_all();
      pin[p] = TBL[i][1];
      cyc(3);
      chk($sformatf("R3 vector %0d flag", i), rdata[p], TBL[i][0]);
      chk($sformatf("R11 vector %0d req", i), req[p], TBL[i][0]);
      if (TBL[i][4:3] == 2'b11)
        chk($sformatf("R10 vector %0d cfg err", i), cerr[p], 1'b1);
      sense[2*p +: 2] = 2'b00;
      cyc(1);
      pin[p] = 1'b1;
      cyc(4);
    end
    clear_all();
    cyc(1);

    // R3 latency: rising code on pin 7
    sense[15:14] = 2'b01;
    pin[7] = 1'b0;
    cyc(4);
    clear_all();
    pin[7] = 1'b1;
    cyc(2);
    chk("R3 not set at second edge", rdata[7], 1'b0);
    cyc(1);
    chk("R3 set at third edge", rdata[7], 1'b1);
    sense[15:14] = 2'b00;
    clear_all();

    // R2 reserved bits and bit position
    do_write(16'hFF00);
    do_read(v);
    chk("R2 reserved bits read zero", v[15:8], 8'h00);
    pin[0] = 1'b0;
    cyc(3);
    do_read(v);
    chk("R2 pin0 maps to bit0", v, 16'h0001);
    pin[0] = 1'b1;
    cyc(3);
    do_write(16'h0000);
    do_read(v);
    chk("R2 bit0 cleared", v, 16'h0000);

    // R5 read-then-write-zero protocol on pin 3
    pin[3] = 1'b0;
    cyc(3);
    do_write(16'h0000);
    do_read(v);
    chk("R5 unarmed write 0 keeps flag", v[3], 1'b1);
    do_write(16'h0008);
    do_write(16'h0000);
    do_read(v);
    chk("R5 write 1 then unread write 0 keeps flag", v[3], 1'b1);
    do_write(16'h0000);
    do_read(v);
    chk("R5 armed write 0 clears", v[3], 1'b0);
    pin[3] = 1'b1;
    cyc(3);

    // R6 exception acknowledge, falling code, pin 2
    pin[2] = 1'b0;
    cyc(3);
    chk("R6 flag set before ack", rdata[2], 1'b1);
    pulse_exc(2);
    chk("R6 exc ack clears edge flag", rdata[2], 1'b0);
    pin[2] = 1'b1;
    cyc(3);

    // R8 transfer acknowledge, pin 1
    pin[1] = 1'b0;
    cyc(3);
    disel = 1'b1;
    pulse_dtc(1);
    chk("R8 dtc ack with disable-select 1 ignored", rdata[1], 1'b1);
    disel = 1'b0;
    pulse_dtc(1);
    chk("R8 dtc ack with disable-select 0 clears", rdata[1], 1'b0);
    disel = 1'b1;
    pin[1] = 1'b1;
    cyc(3);

    // R4 / R7 level mode on pin 5
    lvl[5] = 1'b1;
    cyc(1);
    chk("R4 level req idle", req[5], 1'b0);
    pin[5] = 1'b0;
    cyc(3);
    chk("R4 level req while low", req[5], 1'b1);
    chk("R4 level flag while low", rdata[5], 1'b1);
    pulse_exc(5);
    chk("R7 ack while low keeps flag", rdata[5], 1'b1);
    pin[5] = 1'b1;
    cyc(3);
    chk("R4 level req follows high pin", req[5], 1'b0);
    chk("R7 flag held after release", rdata[5], 1'b1);
    pulse_exc(5);
    chk("R7 ack while high clears", rdata[5], 1'b0);
    lvl[5] = 1'b0;
    cyc(2);

    // R9 set beats clear, both-edge code on pin 4
    sense[9:8] = 2'b10;
    pin[4] = 1'b0;
    cyc(3);
    chk("R9 flag set before collision", rdata[4], 1'b1);
    pin[4] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    exc[4] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exc = '0;
    chk("R9 event wins over same-cycle ack", rdata[4], 1'b1);
    pulse_exc(4);
    chk("R6 lone ack clears both-edge flag", rdata[4], 1'b0);
    sense[9:8] = 2'b00;
    cyc(2);

    // R10 illegal code on pin 6
    sense[13:12] = 2'b11;
    #1 chk("R10 cfg err raised", cerr[6], 1'b1);
    pin[6] = 1'b0;
    cyc(3);
    chk("R10 illegal code sets no flag", rdata[6], 1'b0);
    pin[6] = 1'b1;
    cyc(3);
    sense[13:12] = 2'b00;
    #1 chk("R10 cfg err drops", cerr[6], 1'b0);
    chk("R10 still no flag", rdata[6], 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule